// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block drives the transmit side of an Ethernet controller from a ring of 8-byte buffer descriptors held in system memory. Software places descriptors in memory, programs the ring base, and pulses an activation strobe. The walker then reads descriptors one after another through a simple word-wide memory port. For every descriptor marked ready it copies the payload bytes into an internal frame store and writes the descriptor back with its ready flag cleared. When a descriptor carries the end-of-frame flag, it plays the whole assembled frame out on a byte stream.

A frame may be spread over several descriptors. The walk follows the ring linearly, or returns to the base when a descriptor has its wrap flag set. It halts at the first descriptor that is not ready and keeps that position for the next activation. Frames that would grow past the maximum size are cut short, and a babble event is raised instead of the frame being discarded. Each consumed buffer, each completed frame and each truncation gives a one-cycle event pulse.

Top module: `tdr_engine`

## Requirements
- R1: A descriptor at byte address P has two 32-bit words. Word P holds the buffer length in bits 15:0 and a flag half-word in bits 31:16: ready is word bit 31, wrap is word bit 29, last is word bit 27. Word P+4 is the buffer byte address. The payload byte at address A comes from the memory word at A with bits 1:0 cleared, in lane A[1:0], with lane 0 in bits 7:0.
- R2: An activation strobe starts a walk only while the block is idle and the enable input is high. Otherwise it is ignored and causes no memory access.
- R3: The walk stops at the first descriptor whose ready bit is clear. The current pointer stays on that descriptor, and the next activation resumes there.
- R4: After a descriptor is consumed, the current pointer becomes the ring base if its wrap bit is set, and the current pointer plus 8 otherwise.
- R5: A write to the ring base stores the value with bits 1:0 forced to zero and also loads the current pointer with it. The write is ignored while a walk is in progress.
- R6: Every consumed descriptor has its first word written back with bit 31 cleared and all other bits unchanged, and produces exactly one transmit-buffer pulse.
- R7: On a descriptor with the last bit, the bytes of all buffers since the previous frame end are emitted in order, one per cycle and without gaps, with the final byte marked. A transmit-frame pulse comes with that descriptor's write-back.
- R8: When the accumulated length plus a buffer's length exceeds MAX_FRAME (default 2047), only the bytes that fit are taken and a babble pulse accompanies that descriptor's write-back. The stored length field is not altered.
- R9: A frame whose total length is zero produces a transmit-frame pulse but no stream bytes.
- R10: After reset the block is idle, the base and current pointer are zero, and no stream byte or event is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_en | input | 1 | Controller enable; gates activation |
| tx_go | input | 1 | Transmit activation strobe |
| base_wr | input | 1 | Ring base write strobe |
| base_wdata | input | 32 | Ring base write value |
| base_q | output | 32 | Ring base register |
| cur_ptr | output | 32 | Current descriptor pointer |
| busy | output | 1 | Walk in progress |
| mem_rd | output | 1 | Memory word read request |
| mem_we | output | 1 | Memory word write request |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, valid the cycle after mem_rd |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of a frame |
| ev_txb | output | 1 | Transmit-buffer event pulse |
| ev_txf | output | 1 | Transmit-frame event pulse |
| ev_babt | output | 1 | Babble (truncation) event pulse |

## Verification
The assertions assume that memory returns read data exactly one cycle after a read request, and that descriptors are not changed by anyone else while a walk runs. The bench's memory model has that fixed latency. It serves payload from a computed pattern and changes descriptor words only while busy is low. Base writes during a walk are sent deliberately, to show they are rejected. Every other base write and every descriptor update waits for the idle state.

// File: rtl/tdr_pkg.sv
package tdr_pkg;
  localparam int FLAG_RDY  = 15;
  localparam int FLAG_WRAP = 13;
  localparam int FLAG_LAST = 11;
  localparam logic [31:0] DESC_STRIDE = 32'd8;

  typedef enum logic [3:0] {
    ST_IDLE, ST_D0, ST_D0W, ST_D1, ST_D1W, ST_CPR, ST_CPW, ST_WB, ST_EM
  } tdr_state_e;

  // Next descriptor address after a consumed one.
  function automatic logic [31:0] next_desc(logic [31:0] cur, logic [31:0] base, logic wrap);
    return wrap ? base : cur + DESC_STRIDE;
  endfunction

  // Bytes of a buffer that still fit in the frame.
  function automatic logic [15:0] clip_len(logic [15:0] want, logic [15:0] acc, logic [15:0] maxf);
    logic [16:0] room;
    room = {1'b0, maxf} - {1'b0, acc};
    if ({1'b0, want} > room) return room[15:0];
    return want;
  endfunction

  // Little-endian byte lane of a memory word.
  function automatic logic [7:0] lane_byte(logic [31:0] w, logic [1:0] sel);
    logic [31:0] s;
    s = w >> {sel, 3'b000};
    return s[7:0];
  endfunction
endpackage

// File: rtl/tdr_ptr_regs.sv
module tdr_ptr_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [31:0] load_val,
  input  logic        adv,
  input  logic        wrap,
  output logic [31:0] base_q,
  output logic [31:0] cur_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      cur_q  <= '0;
    end else if (load) begin
      base_q <= load_val & ~32'h3;
      cur_q  <= load_val & ~32'h3;
    end else if (adv) begin
      cur_q <= tdr_pkg::next_desc(cur_q, base_q, wrap);
    end
  end

  // R5
  base_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cur_q == base_q) && (base_q[1:0] == 2'b00));
  // R4
  wrap_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && wrap && !load) |=> cur_q == $past(base_q));
  // R4
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !wrap && !load) |=> cur_q == $past(cur_q) + 32'd8);
endmodule

// File: rtl/tdr_frame_buf.sv
module tdr_frame_buf #(
  parameter int AW = 11,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/tdr_emitter.sv
module tdr_emitter #(
  parameter int MAX_FRAME = 2047,
  parameter int FB_AW = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [15:0]      start_len,
  output logic [FB_AW-1:0] rd_addr,
  input  logic [7:0]       rd_data,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_last
);
  logic        act, v_q, l_q;
  logic [15:0] idx, len_q;
  logic        at_end;

  assign at_end = act && (idx == len_q - 16'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act <= 1'b0; idx <= '0; len_q <= '0; v_q <= 1'b0; l_q <= 1'b0;
    end else begin
      v_q <= act;
      l_q <= at_end;
      if (start) begin
        act <= 1'b1; idx <= '0; len_q <= start_len;
      end else if (act) begin
        idx <= idx + 16'd1;
        if (at_end) act <= 1'b0;
      end
    end
  end

  assign rd_addr   = FB_AW'(idx);
  assign out_valid = v_q;
  assign out_data  = rd_data;
  assign out_last  = l_q;

  // Beat counter for the frame-size window check.
  logic [15:0] beats;
  always_ff @(posedge clk) begin
    if (!rst_n || start) beats <= '0;
    else if (v_q) beats <= beats + 16'd1;
  end

  // R7
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
  // R8
  frame_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> beats < 16'(MAX_FRAME));
endmodule

// File: rtl/tdr_engine.sv
module tdr_engine #(
  parameter int MAX_FRAME = 2047
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrl_en,
  input  logic        tx_go,
  input  logic        base_wr,
  input  logic [31:0] base_wdata,
  output logic [31:0] base_q,
  output logic [31:0] cur_ptr,
  output logic        busy,
  output logic        mem_rd,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  output logic        ev_txb,
  output logic        ev_txf,
  output logic        ev_babt
);
  import tdr_pkg::*;

  localparam int FB_AW = $clog2(MAX_FRAME + 1);
  localparam logic [15:0] MAXW = 16'(MAX_FRAME);
  localparam int RDY_BIT  = 16 + FLAG_RDY;
  localparam int WRAP_BIT = 16 + FLAG_WRAP;
  localparam int LAST_BIT = 16 + FLAG_LAST;

  tdr_state_e  st;
  logic [31:0] w0, bufa, cp_a;
  logic [15:0] take, idx, acc, take_c, frame_len;
  logic        cut, is_last, start_ok, emit_start;
  logic [FB_AW-1:0] fb_raddr;
  logic [7:0]  fb_rdata;

  // Named internal events
  assign start_ok   = (st == ST_IDLE) && tx_go && ctrl_en;
  assign is_last    = w0[LAST_BIT];
  assign take_c     = clip_len(w0[15:0], acc, MAXW);
  assign frame_len  = acc + take;
  assign emit_start = (st == ST_WB) && is_last && (frame_len != 16'd0);
  assign cp_a       = bufa + {16'b0, idx};
  assign busy       = (st != ST_IDLE);

  assign ev_txb  = (st == ST_WB);
  assign ev_txf  = (st == ST_WB) && is_last;
  assign ev_babt = (st == ST_WB) && cut;

  tdr_ptr_regs u_ptr (
    .clk(clk), .rst_n(rst_n),
    .load(base_wr && (st == ST_IDLE)), .load_val(base_wdata),
    .adv(st == ST_WB), .wrap(w0[WRAP_BIT]),
    .base_q(base_q), .cur_q(cur_ptr)
  );

  tdr_frame_buf #(.AW(FB_AW)) u_fb (
    .clk(clk),
    .wr_en(st == ST_CPW), .wr_addr(FB_AW'(acc + idx)),
    .wr_data(lane_byte(mem_rdata, cp_a[1:0])),
    .rd_addr(fb_raddr), .rd_data(fb_rdata)
  );

  tdr_emitter #(.MAX_FRAME(MAX_FRAME), .FB_AW(FB_AW)) u_emit (
    .clk(clk), .rst_n(rst_n),
    .start(emit_start), .start_len(frame_len),
    .rd_addr(fb_raddr), .rd_data(fb_rdata),
    .out_valid(tx_valid), .out_data(tx_data), .out_last(tx_last)
  );

  always_comb begin
    mem_rd = 1'b0; mem_we = 1'b0; mem_addr = cur_ptr; mem_wdata = '0;
    case (st)
      ST_D0:  mem_rd = 1'b1;
      ST_D1:  begin mem_rd = 1'b1; mem_addr = cur_ptr + 32'd4; end
      ST_CPR: begin mem_rd = 1'b1; mem_addr = cp_a; end
      ST_WB:  begin mem_we = 1'b1; mem_wdata = w0 & ~(32'h1 << RDY_BIT); end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; w0 <= '0; bufa <= '0; take <= '0;
      idx <= '0; acc <= '0; cut <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (start_ok) st <= ST_D0;
        ST_D0:   st <= ST_D0W;
        ST_D0W: begin
          w0 <= mem_rdata;
          st <= mem_rdata[RDY_BIT] ? ST_D1 : ST_IDLE;
        end
        ST_D1:   st <= ST_D1W;
        ST_D1W: begin
          bufa <= mem_rdata;
          take <= take_c;
          cut  <= (take_c != w0[15:0]);
          idx  <= '0;
          st   <= (take_c == 16'd0) ? ST_WB : ST_CPR;
        end
        ST_CPR:  st <= ST_CPW;
        ST_CPW: begin
          idx <= idx + 16'd1;
          st  <= (idx + 16'd1 == take) ? ST_WB : ST_CPR;
        end
        ST_WB: begin
          if (is_last && frame_len == 16'd0) begin
            acc <= '0; st <= ST_D0;
          end else begin
            acc <= frame_len;
            st  <= is_last ? ST_EM : ST_D0;
          end
        end
        ST_EM: if (tx_last) begin acc <= '0; st <= ST_D0; end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R2
  go_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && !ctrl_en) |=> !busy && !mem_rd);
  // R3
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_D0W && !mem_rdata[RDY_BIT]) |=> !busy && $stable(cur_ptr));
  // R8
  acc_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WB) |-> frame_len <= MAXW);
  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_txb |=> !ev_txb);
endmodule

// File: tb/tdr_engine_tb.sv
`timescale 1ns/1ps
module tdr_engine_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        ctrl_en = 1'b0, tx_go = 1'b0, base_wr = 1'b0;
  logic [31:0] base_wdata = '0;
  logic [31:0] base_q, cur_ptr, mem_addr, mem_wdata;
  logic [31:0] mem_rdata;
  logic        busy, mem_rd, mem_we, tx_valid, tx_last, ev_txb, ev_txf, ev_babt;
  logic [7:0]  tx_data;

  tdr_engine u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .tx_go(tx_go),
    .base_wr(base_wr), .base_wdata(base_wdata), .base_q(base_q), .cur_ptr(cur_ptr),
    .busy(busy), .mem_rd(mem_rd), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_last(tx_last), .ev_txb(ev_txb), .ev_txf(ev_txf),
    .ev_babt(ev_babt)
  );

  // Payload pattern served above 0x1000
  function automatic logic [7:0] pb(logic [31:0] a);
    logic [31:0] v;
    v = a * 32'd13 + (a >> 8);
    return v[7:0];
  endfunction
  function automatic logic [31:0] pw(logic [31:0] a);
    logic [31:0] b;
    b = {a[31:2], 2'b00};
    return {pb(b + 3), pb(b + 2), pb(b + 1), pb(b)};
  endfunction
  // R1 layout: ready bit 31, wrap bit 29, last bit 27, length 15:0
  function automatic logic [31:0] dw0(int len, bit rdy, bit wrp, bit lst);
    return {rdy, 1'b0, wrp, 1'b0, lst, 11'b0, 16'(len)};
  endfunction

  // Memory model: one-cycle read latency
  logic [31:0] mem [1024];
  logic        tb_we = 1'b0;
  logic [9:0]  tb_a = '0;
  logic [31:0] tb_d = '0;
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 1024; i++) mem[i] <= '0;
    end else begin
      if (tb_we) mem[tb_a] <= tb_d;
      if (mem_we && mem_addr < 32'h1000) mem[mem_addr[11:2]] <= mem_wdata;
    end
    if (mem_rd) mem_rdata <= (mem_addr >= 32'h1000) ? pw(mem_addr) : mem[mem_addr[11:2]];
  end

  // Monitor
  logic [7:0] got [8192];
  int n_got = 0, n_rd = 0, n_txb = 0, n_txf = 0, n_babt = 0, n_lastb = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rd) n_rd++;
      if (ev_txb) n_txb++;
      if (ev_txf) n_txf++;
      if (ev_babt) n_babt++;
      if (tx_valid) begin got[n_got] = tx_data; n_got++; end
      if (tx_last) n_lastb++;
    end
  end

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic poke(logic [31:0] addr, logic [31:0] d);
    @(negedge clk);
    tb_we = 1'b1; tb_a = addr[11:2]; tb_d = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic set_base(logic [31:0] v);
    @(negedge clk);
    base_wr = 1'b1; base_wdata = v;
    @(negedge clk);
    base_wr = 1'b0;
  endtask

  task automatic kick();
    @(negedge clk);
    tx_go = 1'b1;
    @(negedge clk);
    tx_go = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // Compares count bytes starting at got[start] with pattern from addr
  task automatic cmp_bytes(int start, logic [31:0] addr, int count, string req);
    int errs = 0;
    int first = -1;
    for (int i = 0; i < count; i++) begin
      if (got[start + i] !== pb(addr + 32'(i))) begin
        errs++;
        if (first < 0) first = i;
      end
    end
    if (first < 0) chk(1'b1, req, 0, 0);
    else chk(1'b0, req, 32'(got[start + first]), 32'(pb(addr + 32'(first))));
  endtask

  task automatic t_reset();
    chk(!busy, "R10 busy", 32'(busy), 0);
    chk(base_q == 0 && cur_ptr == 0, "R10 pointers", cur_ptr, 0);
    chk(!tx_valid && !ev_txb && !ev_txf && !ev_babt, "R10 outputs", 32'(tx_valid), 0);
  endtask

  task automatic t_base_align();
    set_base(32'h103);
    @(negedge clk);
    chk(base_q == 32'h100, "R5 base align", base_q, 32'h100);
    chk(cur_ptr == 32'h100, "R5 cur reload", cur_ptr, 32'h100);
  endtask

  task automatic t_disabled_go();
    int rd0;
    poke(32'h100, dw0(5, 1, 0, 1));
    poke(32'h104, 32'h1003);
    rd0 = n_rd;
    ctrl_en = 1'b0;
    kick();
    repeat (10) @(negedge clk);
    chk(n_rd == rd0 && !busy, "R2 go ignored when disabled", 32'(n_rd - rd0), 0);
    chk(cur_ptr == 32'h100, "R2 pointer unchanged", cur_ptr, 32'h100);
  endtask

  task automatic t_single();
    int g0 = n_got, b0 = n_txb, f0 = n_txf, l0 = n_lastb;
    ctrl_en = 1'b1;
    kick();
    wait_idle();
    chk(n_got - g0 == 5, "R7 single frame length", 32'(n_got - g0), 5);
    cmp_bytes(g0, 32'h1003, 5, "R1 byte lanes");
    chk(n_txb - b0 == 1 && n_txf - f0 == 1 && n_lastb - l0 == 1, "R6 single events",
        32'(n_txb - b0), 1);
    chk(mem[32'h100 >> 2] == dw0(5, 0, 0, 1), "R6 writeback", mem[32'h100 >> 2], dw0(5, 0, 0, 1));
    chk(cur_ptr == 32'h108, "R3 stops at not-ready", cur_ptr, 32'h108);
  endtask

  task automatic t_multi_wrap();
    int g0, b0, f0;
    poke(32'h200, dw0(3, 1, 0, 0));
    poke(32'h204, 32'h1100);
    poke(32'h208, dw0(4, 1, 1, 1));
    poke(32'h20c, 32'h1200);
    set_base(32'h200);
    g0 = n_got; b0 = n_txb; f0 = n_txf;
    kick();
    wait_idle();
    chk(n_got - g0 == 7, "R7 spanning frame length", 32'(n_got - g0), 7);
    cmp_bytes(g0, 32'h1100, 3, "R7 first buffer bytes");
    cmp_bytes(g0 + 3, 32'h1200, 4, "R7 second buffer bytes");
    chk(n_txb - b0 == 2 && n_txf - f0 == 1, "R6 per-buffer events", 32'(n_txb - b0), 2);
    chk(cur_ptr == 32'h200, "R4 wrap to base", cur_ptr, 32'h200);
  endtask

  task automatic t_resume();
    int g0;
    set_base(32'h300);
    g0 = n_got;
    kick();
    wait_idle();
    chk(cur_ptr == 32'h300 && n_got == g0, "R3 empty ring stays", cur_ptr, 32'h300);
    poke(32'h300, dw0(2, 1, 0, 1));
    poke(32'h304, 32'h1400);
    kick();
    wait_idle();
    chk(n_got - g0 == 2, "R3 resume sends frame", 32'(n_got - g0), 2);
    cmp_bytes(g0, 32'h1400, 2, "R3 resumed bytes");
    chk(cur_ptr == 32'h308, "R4 step by 8", cur_ptr, 32'h308);
  endtask

  task automatic t_zero_len();
    int g0 = n_got, f0 = n_txf;
    poke(32'h308, dw0(0, 1, 0, 1));
    poke(32'h30c, 32'h1500);
    kick();
    wait_idle();
    chk(n_txf - f0 == 1, "R9 frame event", 32'(n_txf - f0), 1);
    chk(n_got == g0, "R9 no stream bytes", 32'(n_got - g0), 0);
    chk(cur_ptr == 32'h310, "R9 pointer advance", cur_ptr, 32'h310);
  endtask

  task automatic t_truncate();
    int g0, k0;
    poke(32'h400, dw0(1500, 1, 0, 0));
    poke(32'h404, 32'h1000);
    poke(32'h408, dw0(1000, 1, 0, 1));
    poke(32'h40c, 32'h1000);
    set_base(32'h400);
    g0 = n_got; k0 = n_babt;
    kick();
    wait_idle();
    chk(n_got - g0 == 2047, "R8 truncated length", 32'(n_got - g0), 2047);
    cmp_bytes(g0, 32'h1000, 1500, "R8 head bytes");
    cmp_bytes(g0 + 1500, 32'h1000, 547, "R8 cut buffer bytes");
    chk(n_babt - k0 == 1, "R8 babble event", 32'(n_babt - k0), 1);
    chk(mem[32'h408 >> 2] == dw0(1000, 0, 0, 1), "R8 length field kept",
        mem[32'h408 >> 2], dw0(1000, 0, 0, 1));
  endtask

  task automatic t_base_busy();
    poke(32'h500, dw0(50, 1, 0, 1));
    poke(32'h504, 32'h1800);
    set_base(32'h500);
    kick();
    repeat (8) @(negedge clk);
    base_wr = 1'b1; base_wdata = 32'h600;
    @(negedge clk);
    base_wr = 1'b0;
    wait_idle();
    chk(base_q == 32'h500, "R5 base write ignored while busy", base_q, 32'h500);
    chk(cur_ptr == 32'h508, "R5 walk unaffected", cur_ptr, 32'h508);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_base_align();
    t_disabled_go();
    t_single();
    t_multi_wrap();
    t_resume();
    t_zero_len();
    t_truncate();
    t_base_busy();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule